// File: doc/BRIEF.md
# Host Bus Mode Strap Latch

This block decides, once per power-on, which kind of host bus the chip is attached to. Two strap pins carry the choice. While power-on reset is held, the block keeps the pad pull-ups and the pad input receivers switched on. It runs the pin levels through a two-stage synchronizer and keeps reloading a capture register from the synchronizer output. When reset is released, the value loaded on the final reset clock is frozen. In the next cycle the pull-up and receiver enables fall, so the pins are ignored from then on.

A pin tied to ground reads as 0. A pin left open reads as 1 because of the pad pull-up. The frozen code is provided in three forms:
- the raw two-bit code;
- a one-hot vector with one line per bus type, for downstream logic;
- a two-bit field in bits 11:10 of a system configuration word. Software reads this word through a small register-read port at IO address 0x000.

Top module: `busmode_strap_latch`

## Requirements
- R1: While `rst` is high, `pullup_en_o` and `rx_en_o` are both 1.
- R2: From the first rising clock edge with `rst` low, `pullup_en_o` and `rx_en_o` are both 0, and they stay 0 until the next reset.
- R3: The captured code equals the strap level that the pins held at the clock edge two cycles before the last edge with `rst` high. A level that arrives later than that edge is not captured. Each new reset samples the pins again.
- R4: After reset is released, any change on `strap_pin_i` leaves `bus_kind_o`, `bus_onehot_o` and the configuration field unchanged.
- R5: Code encoding is 00 = PCI/Mini-PCI, 01 = CardBus, 10 = Sub-ISA, 11 = USB. `bus_onehot_o` bit n is set for code n: bit0 PCI, bit1 CardBus, bit2 Sub-ISA, bit3 USB.
- R6: A read (`rd_en_i` = 1) at address 0x000 returns the captured code in bits 11:10 of `rd_data_o`, with every other bit 0. The data appears on the clock edge after the read request.
- R7: After a cycle with no read, or with a read at any address other than 0x000, `rd_data_o` is all zeros.
- R8: Outside reset, `bus_onehot_o` has exactly one bit set, and that bit is the one selected by `bus_kind_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_pin_i | input | 2 | Strap pin levels from the pads |
| pullup_en_o | output | 1 | Enables the pad pull-ups |
| rx_en_o | output | 1 | Enables the pad input receivers |
| bus_kind_o | output | 2 | Captured host bus code |
| bus_onehot_o | output | 4 | One-hot host bus decode |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 9 | Register read IO address |
| rd_data_o | output | 16 | Register read data, valid one cycle after the request |

## Verification
The hardest case to reach is a strap that changes shortly before reset ends. Whether the new level is captured depends on how many edges it crosses through the synchronizer. The bench therefore changes the pins at exact clock positions before releasing reset. In one case the change comes two edges before release, so the old code must survive. In the other it comes three edges before release, so the new code must be taken. After release the bench toggles the pins through every code and confirms, through the one-hot outputs and register reads, that nothing moves.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

    localparam int STRAP_W   = 2;
    localparam int NUM_KINDS = 1 << STRAP_W;

    typedef enum logic [STRAP_W-1:0] {
        HB_PCI     = 2'b00,
        HB_CARDBUS = 2'b01,
        HB_SUBISA  = 2'b10,
        HB_USB     = 2'b11
    } host_bus_e;

    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_HOLD   = 1'b1
    } strap_phase_e;

    typedef struct packed {
        host_bus_e              kind;
        logic [NUM_KINDS-1:0]   onehot;
    } bus_sel_t;

    function automatic logic [NUM_KINDS-1:0] kind_to_onehot(input host_bus_e k);
        logic [NUM_KINDS-1:0] r;
        r    = '0;
        r[k] = 1'b1;
        return r;
    endfunction

    function automatic bus_sel_t make_sel(input host_bus_e k);
        bus_sel_t s;
        s.kind   = k;
        s.onehot = kind_to_onehot(k);
        return s;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    // Deliberately not reset: the chain must follow the pads while reset is held.
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) stg_q[0] <= pin_i;

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) stg_q[i] <= stg_q[i-1];
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] sync_i,
    output logic               pullup_en_o,
    output logic               rx_en_o,
    output host_bus_e          kind_o
);
    strap_phase_e phase_q;
    host_bus_e    cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SAMPLE;
            cap_q   <= host_bus_e'(sync_i);
        end else begin
            phase_q <= PH_HOLD;
        end
    end

    assign pullup_en_o = (phase_q == PH_SAMPLE);
    assign rx_en_o     = (phase_q == PH_SAMPLE);
    assign kind_o      = cap_q;

    // R2: pads are released once a full cycle out of reset has passed
    p_pads_off_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (!pullup_en_o && !rx_en_o));

    // R4: the captured code never moves outside reset
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(kind_o));
endmodule

// File: rtl/strap_cfg_read.sv
module strap_cfg_read
    import strap_mode_pkg::*;
#(
    parameter int                ADDR_W    = 9,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = '0,
    parameter int                FIELD_LSB = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  host_bus_e          kind_i,
    output logic [DATA_W-1:0]  rd_data_o
);
    localparam int FIELD_MSB = FIELD_LSB + STRAP_W - 1;

    logic [DATA_W-1:0] cfg_word;
    logic              hit;

    always_comb begin
        cfg_word = '0;
        cfg_word[FIELD_LSB +: STRAP_W] = kind_i;
    end

    assign hit = rd_en_i && (rd_addr_i == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (rst)      rd_data_o <= '0;
        else if (hit) rd_data_o <= cfg_word;
        else          rd_data_o <= '0;
    end

    // R6: a hit returns the live code in the field
    p_field_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en_i) && $past(rd_addr_i) == CFG_ADDR && !$past(rst))
        |-> rd_data_o[FIELD_MSB:FIELD_LSB] == kind_i);

    // R7: no read in the previous cycle leaves the bus at zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en_i) |-> rd_data_o == '0);
endmodule

// File: rtl/busmode_strap_latch.sv
module busmode_strap_latch
    import strap_mode_pkg::*;
#(
    parameter int                ADDR_W      = 9,
    parameter int                DATA_W      = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = '0,
    parameter int                FIELD_LSB   = 10,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STRAP_W-1:0]    strap_pin_i,
    output logic                  pullup_en_o,
    output logic                  rx_en_o,
    output logic [STRAP_W-1:0]    bus_kind_o,
    output logic [NUM_KINDS-1:0]  bus_onehot_o,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o
);
    logic [STRAP_W-1:0] sync_val;
    host_bus_e          kind;
    bus_sel_t           sel;

    strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .pin_i  (strap_pin_i),
        .sync_o (sync_val)
    );

    strap_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .sync_i      (sync_val),
        .pullup_en_o (pullup_en_o),
        .rx_en_o     (rx_en_o),
        .kind_o      (kind)
    );

    strap_cfg_read #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CFG_ADDR  (CFG_ADDR),
        .FIELD_LSB (FIELD_LSB)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .kind_i    (kind),
        .rd_data_o (rd_data_o)
    );

    assign sel          = make_sel(kind);
    assign bus_kind_o   = sel.kind;
    assign bus_onehot_o = sel.onehot;

    // R8: exactly one decode line, matching the code
    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        ($countones(bus_onehot_o) == 1) && bus_onehot_o[bus_kind_o]);
endmodule

// File: tb/busmode_strap_latch_tb.sv
module busmode_strap_latch_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  strap_pin_i = 2'b00;
    logic        pullup_en_o, rx_en_o;
    logic [1:0]  bus_kind_o;
    logic [3:0]  bus_onehot_o;
    logic        rd_en_i = 1'b0;
    logic [8:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    busmode_strap_latch u_dut (
        .clk(clk), .rst(rst), .strap_pin_i(strap_pin_i),
        .pullup_en_o(pullup_en_o), .rx_en_o(rx_en_o),
        .bus_kind_o(bus_kind_o), .bus_onehot_o(bus_onehot_o),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    typedef struct {
        string       req;
        logic [15:0] exp;
    } item_t;
    item_t sb_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // driver: push expectation, issue one-cycle read
    task automatic rd(input logic [8:0] a, input logic [15:0] exp, input string req);
        sb_q.push_back('{req: req, exp: exp});
        rd_addr_i = a;
        rd_en_i   = 1'b1;
        @(negedge clk);
        rd_en_i   = 1'b0;
    endtask

    // monitor: a read seen at a posedge is compared at the next negedge
    logic saw_rd = 1'b0;
    always @(posedge clk) saw_rd <= rd_en_i;
    always @(negedge clk) begin
        if (saw_rd && !done) begin
            if (sb_q.size() == 0) chk("R6 scoreboard underflow", 1, 0);
            else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, {16'h0, rd_data_o}, {16'h0, it.exp});
            end
        end
    end

    function automatic logic [15:0] fld(input logic [1:0] m);
        return {4'h0, m, 10'h0};
    endfunction

    // hold reset with a steady strap, then release and check the result
    task automatic power_on(input logic [1:0] val, input int cyc);
        rst = 1'b1;
        strap_pin_i = val;
        repeat (cyc) @(negedge clk);
        chk("R1 pullup_en in reset", pullup_en_o, 1);
        chk("R1 rx_en in reset", rx_en_o, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 pullup_en after release", pullup_en_o, 0);
        chk("R2 rx_en after release", rx_en_o, 0);
        chk("R3 captured code", bus_kind_o, val);
        chk("R5 R8 onehot decode", bus_onehot_o, 4'b0001 << val);
    endtask

    initial begin
        // R5: each code in turn, via outputs and register read (R6)
        for (int m = 0; m < 4; m++) begin
            power_on(m[1:0], 6);
            rd(9'h000, fld(m[1:0]), "R6 cfg field");
        end

        // R4: pins wander after release, nothing moves
        power_on(2'b10, 6);
        for (int m = 0; m < 4; m++) begin
            strap_pin_i = m[1:0];
            repeat (3) @(negedge clk);
            chk("R4 code stable", bus_kind_o, 2'b10);
            chk("R4 onehot stable", bus_onehot_o, 4'b0100);
            chk("R2 pads stay off", {pullup_en_o, rx_en_o}, 2'b00);
            rd(9'h000, fld(2'b10), "R4 cfg field stable");
        end

        // R7: other addresses and idle cycles give zero
        rd(9'h001, 16'h0, "R7 other address");
        rd(9'h100, 16'h0, "R7 high address");
        @(negedge clk);
        chk("R7 idle zero", rd_data_o, 0);

        // R3: late change, two edges before release -> old code kept
        rst = 1'b1; strap_pin_i = 2'b01;
        repeat (6) @(negedge clk);
        strap_pin_i = 2'b11;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 late change ignored", bus_kind_o, 2'b01);

        // R3: change three edges before release -> new code taken
        rst = 1'b1; strap_pin_i = 2'b01;
        repeat (6) @(negedge clk);
        strap_pin_i = 2'b11;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 early change taken", bus_kind_o, 2'b11);
        rd(9'h000, fld(2'b11), "R6 cfg after resample");
        strap_pin_i = 2'b00;
        repeat (3) @(negedge clk);
        chk("R3 queue drained", sb_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule